// File: doc/BRIEF.md
# Logical Instruction Execute Unit

This unit executes the bitwise logical subset of a 32-bit, three-register instruction set in a single clock. Each cycle with the valid strobe high, it takes one instruction word. It decodes the word and reads two operands from its private register file. At the next rising edge it writes the AND, OR, XOR or NOR result back. Register forms combine two registers. Immediate forms combine one register with a 16-bit constant that is always padded with zeros. Immediate forms have no NOR.

Words that do not name one of these seven operations are rejected: the illegal flag pulses for one cycle and no register is written. A legal word pulses the writeback-done flag instead. A combinational debug port returns any register's current contents. Loading constants relies on an OR-immediate from register 0. Negation relies on an XOR against a register that holds all ones.

Top module: `logic_exec_unit`

## Requirements
- R1: A rising edge with `rst` high clears every register to zero and leaves `illegal` and `wbDone` low in the following cycle.
- R2: The word is split as opcode [31:26], first source [25:21], second source [20:16], register-form destination [15:11], shift field [10:6] and function [5:0]. A register form has opcode 000000, a zero shift field and one of these function codes: 100100 AND, 100101 OR, 100110 XOR, 100111 NOR. It writes the result of the two source registers into the destination in [15:11].
- R3: The immediate forms are opcode 001100 AND, 001101 OR and 001110 XOR. Each combines the register in [25:21] with the constant in [15:0] and writes the register named in [20:16].
- R4: The immediate is extended with zeros and never with its bit 15. An immediate AND always yields zero in bits 31..16, and an immediate OR or XOR leaves those bits equal to the source register's.
- R5: Register 0 always reads as zero. A legal instruction that targets it changes no register.
- R6: All other words raise `illegal` for exactly the cycle after the edge, and no register changes. This covers every other opcode (including 001111, which has no immediate NOR), every other function code under opcode 000000, and a nonzero shift field on a register form.
- R7: `wbDone` is high for exactly the cycle after an edge that accepted a valid legal instruction, including one that targets register 0. `illegal` and `wbDone` are never high together.
- R8: While `instrValid` is low, the word is ignored: no register changes and both flags stay low.
- R9: `dbgData` shows the current contents of the register selected by `dbgAddr`, with no clock delay.
- R10: Instructions may arrive on consecutive cycles. An instruction reads the value that the previous instruction wrote at the edge between them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| instrValid | input | 1 | Instruction word is present this cycle |
| instrWord | input | 32 | Instruction word |
| dbgAddr | input | 5 | Register selected for the debug read |
| dbgData | output | DATA_W | Contents of the selected register |
| illegal | output | 1 | One-cycle pulse: the previous word was rejected |
| wbDone | output | 1 | One-cycle pulse: the previous word was executed |

## Verification
The bench builds the unit with its default 32-bit data width and 32 registers, so all of the register file can be reached through the debug port. At this width, bit 15 of an immediate sits directly below a full upper half. That lets the bench show that constants with the top bit set never spill ones upward. It also lets it show that an XOR against the all-ones value produced by a NOR of register 0 inverts all 32 bits. After every rejected or unstrobed word, all 32 registers are compared with a reference model. Runs of back-to-back words show that each result is forwarded through the register file.

// File: rtl/lx_pkg.sv
package lx_pkg;

  localparam int INSTR_W = 32;
  localparam int REG_AW  = 5;
  localparam int REG_CNT = 1 << REG_AW;
  localparam int IMM_W   = 16;

  localparam logic [5:0] OPC_REGFORM = 6'b000000;
  localparam logic [5:0] OPC_ANDI    = 6'b001100;
  localparam logic [5:0] OPC_ORI     = 6'b001101;
  localparam logic [5:0] OPC_XORI    = 6'b001110;

  localparam logic [5:0] FN_AND = 6'b100100;
  localparam logic [5:0] FN_OR  = 6'b100101;
  localparam logic [5:0] FN_XOR = 6'b100110;
  localparam logic [5:0] FN_NOR = 6'b100111;

  typedef enum logic [1:0] {
    LOP_AND,
    LOP_OR,
    LOP_XOR,
    LOP_NOR
  } lop_e;

  typedef struct packed {
    logic [5:0]        opcode;
    logic [REG_AW-1:0] srcA;
    logic [REG_AW-1:0] srcB;
    logic [REG_AW-1:0] dstR;
    logic [4:0]        shamt;
    logic [5:0]        funct;
  } instr_t;

  typedef struct packed {
    logic              wrEn;
    logic              useImm;
    lop_e              op;
    logic [REG_AW-1:0] rdA;
    logic [REG_AW-1:0] rdB;
    logic [REG_AW-1:0] dest;
    logic [IMM_W-1:0]  imm;
  } ctrl_t;

endpackage

// File: rtl/lx_decode.sv
module lx_decode
  import lx_pkg::*;
(
  input  logic                clk,
  input  logic                rst,
  input  logic                instrValid,
  input  logic [INSTR_W-1:0]  instrWord,
  output ctrl_t               ctrl,
  output logic                illegal,
  output logic                wbDone
);

  instr_t fields;
  logic   isLegal;
  logic   rejectNow;
  logic   useImm;
  lop_e   op;
  logic [REG_AW-1:0] dest;

  assign fields = instr_t'(instrWord);

  always_comb begin
    isLegal = 1'b0;
    useImm  = 1'b0;
    op      = LOP_AND;
    dest    = fields.dstR;
    unique case (fields.opcode)
      OPC_REGFORM: begin
        if (fields.shamt == 5'd0) begin
          unique case (fields.funct)
            FN_AND:  begin isLegal = 1'b1; op = LOP_AND; end
            FN_OR:   begin isLegal = 1'b1; op = LOP_OR;  end
            FN_XOR:  begin isLegal = 1'b1; op = LOP_XOR; end
            FN_NOR:  begin isLegal = 1'b1; op = LOP_NOR; end
            default: isLegal = 1'b0;
          endcase
        end
      end
      OPC_ANDI: begin isLegal = 1'b1; useImm = 1'b1; op = LOP_AND; dest = fields.srcB; end
      OPC_ORI:  begin isLegal = 1'b1; useImm = 1'b1; op = LOP_OR;  dest = fields.srcB; end
      OPC_XORI: begin isLegal = 1'b1; useImm = 1'b1; op = LOP_XOR; dest = fields.srcB; end
      default:  isLegal = 1'b0;
    endcase
  end

  assign rejectNow   = instrValid && !isLegal;
  assign ctrl.wrEn   = instrValid && isLegal;
  assign ctrl.useImm = useImm;
  assign ctrl.op     = op;
  assign ctrl.rdA    = fields.srcA;
  assign ctrl.rdB    = fields.srcB;
  assign ctrl.dest   = dest;
  assign ctrl.imm    = instrWord[IMM_W-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      illegal <= 1'b0;
      wbDone  <= 1'b0;
    end else begin
      illegal <= rejectNow;
      wbDone  <= ctrl.wrEn;
    end
  end

  // R7: the two outcome flags exclude each other
  a_r7_flags_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(illegal && wbDone));

  // R8: no flag without a strobe in the cycle before
  a_r8_flag_needs_valid: assert property (@(posedge clk) disable iff (rst)
    (illegal || wbDone) |-> $past(instrValid));

  // R6: a rejected word never produced a write strobe
  a_r6_reject_no_write: assert property (@(posedge clk) disable iff (rst)
    illegal |-> !$past(ctrl.wrEn));

endmodule

// File: rtl/lx_regfile.sv
module lx_regfile
  import lx_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int NUM_RD = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wrEn,
  input  logic [REG_AW-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic [REG_AW-1:0] rdAddr [NUM_RD],
  output logic [DATA_W-1:0] rdData [NUM_RD]
);

  logic [DATA_W-1:0] regs [REG_CNT];

  always_ff @(posedge clk) begin
    for (int i = 0; i < REG_CNT; i++) begin
      if (rst) begin
        regs[i] <= '0;
      end else if (wrEn && (wrAddr != '0) && (wrAddr == REG_AW'(i))) begin
        regs[i] <= wrData;
      end
    end
  end

  for (genvar p = 0; p < NUM_RD; p++) begin : gRead
    assign rdData[p] = (rdAddr[p] == '0) ? '0 : regs[rdAddr[p]];
  end

  // R5: the zero register never holds anything but zero
  a_r5_zero_reg: assert property (@(posedge clk) disable iff (rst)
    regs[0] == '0);

  // R2: a write to a nonzero register lands at the next edge
  a_r2_write_lands: assert property (@(posedge clk) disable iff (rst)
    (wrEn && wrAddr != '0) |=> regs[$past(wrAddr)] == $past(wrData));

endmodule

// File: rtl/lx_datapath.sv
module lx_datapath
  import lx_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  ctrl_t             ctrl,
  input  logic [REG_AW-1:0] dbgAddr,
  output logic [DATA_W-1:0] dbgData
);

  localparam int NUM_RD = 3;
  localparam int PAD_W  = DATA_W - IMM_W;

  logic [REG_AW-1:0] rdAddr [NUM_RD];
  logic [DATA_W-1:0] rdData [NUM_RD];
  logic [DATA_W-1:0] operandA;
  logic [DATA_W-1:0] operandB;
  logic [DATA_W-1:0] result;

  assign rdAddr[0] = ctrl.rdA;
  assign rdAddr[1] = ctrl.rdB;
  assign rdAddr[2] = dbgAddr;

  lx_regfile #(
    .DATA_W (DATA_W),
    .NUM_RD (NUM_RD)
  ) uRegs (
    .clk    (clk),
    .rst    (rst),
    .wrEn   (ctrl.wrEn),
    .wrAddr (ctrl.dest),
    .wrData (result),
    .rdAddr (rdAddr),
    .rdData (rdData)
  );

  assign operandA = rdData[0];
  assign operandB = ctrl.useImm ? {{PAD_W{1'b0}}, ctrl.imm} : rdData[1];
  assign dbgData  = rdData[2];

  always_comb begin
    unique case (ctrl.op)
      LOP_AND: result = operandA & operandB;
      LOP_OR:  result = operandA | operandB;
      LOP_XOR: result = operandA ^ operandB;
      LOP_NOR: result = ~(operandA | operandB);
      default: result = '0;
    endcase
  end

  // R4: an immediate AND can never set the upper half
  a_r4_andi_upper_zero: assert property (@(posedge clk) disable iff (rst)
    (ctrl.wrEn && ctrl.useImm && ctrl.op == LOP_AND) |-> result[DATA_W-1:IMM_W] == '0);

endmodule

// File: rtl/logic_exec_unit.sv
module logic_exec_unit
  import lx_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                instrValid,
  input  logic [INSTR_W-1:0]  instrWord,
  input  logic [REG_AW-1:0]   dbgAddr,
  output logic [DATA_W-1:0]   dbgData,
  output logic                illegal,
  output logic                wbDone
);

  ctrl_t ctrl;

  lx_decode uDecode (
    .clk        (clk),
    .rst        (rst),
    .instrValid (instrValid),
    .instrWord  (instrWord),
    .ctrl       (ctrl),
    .illegal    (illegal),
    .wbDone     (wbDone)
  );

  lx_datapath #(
    .DATA_W (DATA_W)
  ) uData (
    .clk     (clk),
    .rst     (rst),
    .ctrl    (ctrl),
    .dbgAddr (dbgAddr),
    .dbgData (dbgData)
  );

endmodule

// File: tb/tb_logic_exec_unit.sv
`timescale 1ns/100ps
module tb_logic_exec_unit;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        instrValid = 1'b0;
  logic [31:0] instrWord = '0;
  logic [4:0]  dbgAddr = '0;
  logic [31:0] dbgData;
  logic        illegal;
  logic        wbDone;

  int tests = 0;
  int fails = 0;
  bit done  = 1'b0;

  typedef struct {
    bit    ill;
    bit    wb;
    string tag;
  } exp_t;

  exp_t        expQ[$];
  exp_t        mItem;
  logic [31:0] refRegs [32];

  always #2.5 clk = ~clk;

  logic_exec_unit dut (
    .clk        (clk),
    .rst        (rst),
    .instrValid (instrValid),
    .instrWord  (instrWord),
    .dbgAddr    (dbgAddr),
    .dbgData    (dbgData),
    .illegal    (illegal),
    .wbDone     (wbDone)
  );

  // monitor: flags settle one edge after the word is presented
  always @(posedge clk) begin
    #1;
    if (expQ.size() != 0) begin
      mItem = expQ.pop_front();
      tests++;
      if (illegal !== mItem.ill || wbDone !== mItem.wb) begin
        fails++;
        $display("FAIL %s flags: illegal=%0b wbDone=%0b expected illegal=%0b wbDone=%0b",
                 mItem.tag, illegal, wbDone, mItem.ill, mItem.wb);
      end
    end
  end

  function automatic logic [31:0] rForm(input logic [5:0] fn, input int s, input int t,
                                        input int d, input logic [4:0] sh);
    return {6'b000000, 5'(s), 5'(t), 5'(d), sh, fn};
  endfunction

  function automatic logic [31:0] iForm(input logic [5:0] opc, input int s, input int t,
                                        input logic [15:0] imm);
    return {opc, 5'(s), 5'(t), imm};
  endfunction

  task automatic issue(input logic [31:0] w, input bit v, input string tag);
    logic [5:0]  opc;
    logic [31:0] a, b, res;
    int          dst;
    bit          ok;
    exp_t        e;
    opc = w[31:26];
    a   = refRegs[w[25:21]];
    b   = refRegs[w[20:16]];
    ok  = 1'b0;
    res = '0;
    dst = int'(w[15:11]);
    if (opc == 6'b000000 && w[10:6] == 5'd0) begin
      case (w[5:0])
        6'b100100: begin ok = 1'b1; res = a & b;    end
        6'b100101: begin ok = 1'b1; res = a | b;    end
        6'b100110: begin ok = 1'b1; res = a ^ b;    end
        6'b100111: begin ok = 1'b1; res = ~(a | b); end
        default:   ok = 1'b0;
      endcase
    end else begin
      dst = int'(w[20:16]);
      case (opc)
        6'b001100: begin ok = 1'b1; res = a & {16'h0, w[15:0]}; end
        6'b001101: begin ok = 1'b1; res = a | {16'h0, w[15:0]}; end
        6'b001110: begin ok = 1'b1; res = a ^ {16'h0, w[15:0]}; end
        default:   ok = 1'b0;
      endcase
    end
    @(negedge clk);
    instrWord  = w;
    instrValid = v;
    e.ill = v && !ok;
    e.wb  = v && ok;
    e.tag = tag;
    expQ.push_back(e);
    @(posedge clk);
    if (v && ok && dst != 0) refRegs[dst] = res;
    #1;
    instrValid = 1'b0;
  endtask

  task automatic checkReg(input int r, input string tag);
    dbgAddr = 5'(r);
    #0.2;
    tests++;
    if (dbgData !== refRegs[r]) begin
      fails++;
      $display("FAIL %s reg r%0d: got %h expected %h", tag, r, dbgData, refRegs[r]);
    end
  endtask

  task automatic checkAll(input string tag);
    for (int r = 0; r < 32; r++) begin
      dbgAddr = 5'(r);
      #0.05;
      if (dbgData !== refRegs[r]) begin
        fails++;
        $display("FAIL %s sweep r%0d: got %h expected %h", tag, r, dbgData, refRegs[r]);
      end
    end
    tests++;
  endtask

  task automatic doReset();
    exp_t e;
    @(negedge clk);
    rst        = 1'b1;
    instrValid = 1'b0;
    e.ill = 1'b0;
    e.wb  = 1'b0;
    e.tag = "R1 reset";
    expQ.push_back(e);
    @(posedge clk);
    for (int r = 0; r < 32; r++) refRegs[r] = '0;
    #1;
    rst = 1'b0;
  endtask

  initial begin
    for (int r = 0; r < 32; r++) refRegs[r] = 32'hDEAD_BEEF;
    repeat (2) @(posedge clk);
    doReset();
    checkAll("R1 cleared");

    // constants via immediate OR from register 0
    issue(iForm(6'b001101, 0, 1, 16'hF0F0), 1, "R3 ori");
    checkReg(1, "R3 ori");
    issue(iForm(6'b001101, 0, 2, 16'h8001), 1, "R4 ori top bit");
    checkReg(2, "R4 ori top bit");
    issue(rForm(6'b100111, 0, 0, 3, 5'd0), 1, "R2 nor ones");
    checkReg(3, "R2 nor ones");
    issue(rForm(6'b100110, 1, 3, 4, 5'd0), 1, "R2 xor invert");
    checkReg(4, "R2 xor invert");
    issue(iForm(6'b001100, 4, 5, 16'hFFFF), 1, "R4 andi");
    checkReg(5, "R4 andi");
    issue(iForm(6'b001110, 3, 6, 16'h8000), 1, "R4 xori top bit");
    checkReg(6, "R4 xori top bit");
    issue(iForm(6'b001101, 4, 7, 16'h8000), 1, "R4 ori keeps upper");
    checkReg(7, "R4 ori keeps upper");
    issue(iForm(6'b001100, 3, 12, 16'h8000), 1, "R4 andi from ones");
    checkReg(12, "R4 andi from ones");
    issue(rForm(6'b100100, 7, 6, 8, 5'd0), 1, "R2 and");
    checkReg(8, "R2 and");
    issue(rForm(6'b100101, 2, 1, 9, 5'd0), 1, "R2 or");
    checkReg(9, "R2 or");
    issue(rForm(6'b100111, 7, 2, 10, 5'd0), 1, "R2 nor");
    checkReg(10, "R2 nor");
    issue(rForm(6'b100110, 9, 9, 11, 5'd0), 1, "R2 xor self");
    checkReg(11, "R2 xor self");

    // R10: back-to-back dependent words
    issue(iForm(6'b001101, 0, 13, 16'h1111), 1, "R10 first");
    issue(iForm(6'b001101, 13, 13, 16'h2222), 1, "R10 chained");
    issue(rForm(6'b100110, 13, 3, 14, 5'd0), 1, "R10 chained rform");
    issue(rForm(6'b100100, 14, 4, 15, 5'd0), 1, "R10 chained again");
    checkAll("R10 back-to-back");

    // R5: writes to register 0 vanish but still complete
    issue(iForm(6'b001101, 0, 0, 16'hFFFF), 1, "R5 ori to r0");
    issue(rForm(6'b100101, 3, 3, 0, 5'd0), 1, "R5 or to r0");
    checkReg(0, "R5 zero reg");
    checkAll("R5 untouched");

    // R6: rejected words
    issue(rForm(6'b100000, 1, 2, 20, 5'd0), 1, "R6 bad funct");
    issue(rForm(6'b100011, 1, 2, 21, 5'd0), 1, "R6 absent nand-like funct");
    issue(rForm(6'b100100, 1, 2, 22, 5'd1), 1, "R6 nonzero shamt");
    issue(rForm(6'b100111, 1, 2, 23, 5'd16), 1, "R6 nor with shamt");
    issue(iForm(6'b001111, 3, 24, 16'h1234), 1, "R6 no nori");
    issue(iForm(6'b001000, 3, 25, 16'h0001), 1, "R6 other opcode");
    issue(iForm(6'b000100, 3, 26, 16'h0001), 1, "R6 branch opcode");
    checkAll("R6 no write");

    // R7: reject then accept, flags pulse one cycle each
    issue(iForm(6'b111111, 1, 27, 16'h0F0F), 1, "R7 reject");
    issue(iForm(6'b001110, 1, 27, 16'h0F0F), 1, "R7 accept");
    issue(iForm(6'b001101, 0, 28, 16'h0001), 0, "R7 idle after");
    checkReg(27, "R7 accept");

    // R8: unstrobed words ignored
    issue(iForm(6'b001101, 0, 1, 16'hAAAA), 0, "R8 ignored ori");
    issue(rForm(6'b100111, 0, 0, 9, 5'd0), 0, "R8 ignored nor");
    checkAll("R8 unchanged");

    // R9: debug port follows address without clock
    checkReg(6, "R9 debug");
    checkReg(3, "R9 debug");

    // R1: reset in mid-run
    doReset();
    checkAll("R1 mid-run reset");
    issue(rForm(6'b100111, 0, 0, 31, 5'd0), 1, "R1 after reset");
    checkReg(31, "R1 after reset");

    repeat (3) @(posedge clk);
    #1;
    if (!done) begin
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      tests++;
      fails++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

endmodule